// File: doc/BRIEF.md
# Serial EEPROM Port Arbiter

This block is a small control register that lets software drive an external one-bit serial EEPROM by hand, bit by bit. The EEPROM sits behind a memory port that another requester also uses. Software sets a request bit. The block waits until the other requester no longer holds the port, then takes the port and reports the grant through a ready bit. From then on, three register bits drive the EEPROM select, clock and data-out pins, and a fourth bit shows the level on the EEPROM's data-output pin.

After the grant, the ready bit becomes a pacing timer. Each write to the register pulls ready low. Ready comes back high a fixed 800 ns after the most recent write, so software can toggle the serial clock at a safe rate by polling one bit. The delay is a cycle count computed from the clock-frequency parameter and rounded up. Clearing the request bit releases the port and returns every pin to its inactive low level.

Top module: `sprom_port_arb`

## Requirements
- R1: After reset, the read value is 0x00, the port-ownership output is low and the select, clock and data pins are low.
- R2: The register bits are: request bit 5, ready bit 4, select bit 3, clock bit 2, data-out bit 1, data-in bit 0. Bits 7:6 read as zero. A write that sets bit 5 while the port is idle and not owned grants the port at that clock edge: ownership and ready (bit 4) read high from the next cycle, with no timer delay.
- R3: While the other requester is busy, a pending request is not granted and waits with no time limit. The grant follows at the first edge where the port is seen idle.
- R4: Once the port is granted, a write to the register drops ready at that edge. Ready returns high exactly PACE_CYC cycles later, where PACE_CYC is CLK_HZ x READY_NS / 1e9 rounded up (100 at the defaults).
- R5: A write made while ready is low restarts the delay, so ready rises PACE_CYC cycles after the last write.
- R6: While the port is granted, the select, clock and data-out pins follow register bits 3, 2 and 1 from the edge of the write that sets them. While it is not granted they stay low. Bits 3:1 always read back as written.
- R7: While the port is granted, bit 0 shows the EEPROM data-output pin as sampled at the previous edge. While it is not granted, bit 0 reads zero.
- R8: A write that clears bit 5 releases the port at that edge. Ownership, ready and all three pins go low, and any running delay is cancelled.
- R9: Once the port is granted, the busy input from the other requester has no effect until the request is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Register write strobe |
| ctl_wdata | input | 8 | Register write data |
| ctl_rdata | output | 8 | Register read value |
| mem_busy | input | 1 | Other requester is using the memory port |
| ee_owns_port | output | 1 | Port granted to the EEPROM path |
| ee_cs | output | 1 | EEPROM chip select |
| ee_clk | output | 1 | EEPROM serial clock |
| ee_dout | output | 1 | Data driven to the EEPROM |
| ee_din | input | 1 | Data returned by the EEPROM |

## Verification
The bench builds the block with its defaults, a 125 MHz clock and an 800 ns delay, so the ready window is 100 cycles. That is short enough to probe both the last low cycle and the rising edge, and to restart the window halfway through. It holds a request pending for 300 cycles to show that a waiting request never times out. It also releases the port in the middle of a running window to show that the next grant reports ready at once.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
  localparam int unsigned REQ_B  = 5;
  localparam int unsigned RDY_B  = 4;
  localparam int unsigned CS_B   = 3;
  localparam int unsigned SK_B   = 2;
  localparam int unsigned DO_B   = 1;
  localparam int unsigned DI_B   = 0;
  localparam int unsigned NPINS  = 3;
  localparam longint unsigned NS_PER_S = 64'd1_000_000_000;

  // Delay in clock cycles, rounded up, never below one.
  function automatic int unsigned pace_cycles(longint unsigned hz, longint unsigned ns);
    longint unsigned raw;
    raw = (hz * ns + NS_PER_S - 64'd1) / NS_PER_S;
    return (raw == 64'd0) ? 1 : int'(raw);
  endfunction
endpackage

// File: rtl/sprom_ctl_reg.sv
module sprom_ctl_reg
  import sprom_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             req_in,
  input  logic [NPINS-1:0] pins_in,
  output logic             req_nxt,
  output logic             req_q,
  output logic [NPINS-1:0] pins_nxt,
  output logic [NPINS-1:0] pins_q
);
  always_comb begin
    req_nxt  = wr ? req_in  : req_q;
    pins_nxt = wr ? pins_in : pins_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      pins_q <= '0;
    end else begin
      req_q  <= req_nxt;
      pins_q <= pins_nxt;
    end
  end
endmodule

// File: rtl/sprom_arbiter.sv
module sprom_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic req_nxt,
  input  logic mem_busy,
  output logic grant_nxt,
  output logic grant_q
);
  // Held while requested; taken only when the other side is idle.
  always_comb grant_nxt = req_nxt & (grant_q | ~mem_busy);

  always_ff @(posedge clk) begin
    if (rst) grant_q <= 1'b0;
    else     grant_q <= grant_nxt;
  end
endmodule

// File: rtl/sprom_pace_timer.sv
module sprom_pace_timer #(
  parameter int unsigned CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic clear,
  output logic idle
);
  localparam int unsigned W = $clog2(CYCLES + 1);
  localparam logic [W-1:0] LOAD_VAL = W'(CYCLES);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear)      cnt_q <= '0;
    else if (load)         cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  always_comb idle = (cnt_q == '0);
endmodule

// File: rtl/sprom_pin_mux.sv
module sprom_pin_mux
  import sprom_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             grant_nxt,
  input  logic             grant_q,
  input  logic [NPINS-1:0] bits_nxt,
  input  logic             ee_in,
  output logic [NPINS-1:0] pins,
  output logic             din_q
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) pins[i] <= 1'b0;
      else     pins[i] <= grant_nxt & bits_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) din_q <= 1'b0;
    else     din_q <= grant_q & ee_in;
  end
endmodule

// File: rtl/sprom_port_arb.sv
module sprom_port_arb
  import sprom_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 125_000_000,
  parameter longint unsigned READY_NS = 800
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       mem_busy,
  output logic       ee_owns_port,
  output logic       ee_cs,
  output logic       ee_clk,
  output logic       ee_dout,
  input  logic       ee_din
);
  localparam int unsigned PACE_CYC = pace_cycles(CLK_HZ, READY_NS);

  logic             req_nxt, req_q;
  logic [NPINS-1:0] bits_in, bits_nxt, bits_q, pins;
  logic             grant_nxt, grant_q, tmr_idle, din_q;
  logic             unused_wbits;

  // Pin vector order: [2] select, [1] clock, [0] data-out.
  always_comb begin
    bits_in      = {ctl_wdata[CS_B], ctl_wdata[SK_B], ctl_wdata[DO_B]};
    unused_wbits = ^{ctl_wdata[7:6], ctl_wdata[RDY_B], ctl_wdata[DI_B]};
  end

  sprom_ctl_reg u_reg (
    .clk(clk), .rst(rst), .wr(ctl_wr), .req_in(ctl_wdata[REQ_B]),
    .pins_in(bits_in), .req_nxt(req_nxt), .req_q(req_q),
    .pins_nxt(bits_nxt), .pins_q(bits_q)
  );

  sprom_arbiter u_arb (
    .clk(clk), .rst(rst), .req_nxt(req_nxt), .mem_busy(mem_busy),
    .grant_nxt(grant_nxt), .grant_q(grant_q)
  );

  sprom_pace_timer #(.CYCLES(PACE_CYC)) u_tmr (
    .clk(clk), .rst(rst), .load(ctl_wr & grant_q), .clear(~grant_nxt),
    .idle(tmr_idle)
  );

  sprom_pin_mux u_mux (
    .clk(clk), .rst(rst), .grant_nxt(grant_nxt), .grant_q(grant_q),
    .bits_nxt(bits_nxt), .ee_in(ee_din), .pins(pins), .din_q(din_q)
  );

  always_comb begin
    ctl_rdata        = '0;
    ctl_rdata[REQ_B] = req_q;
    ctl_rdata[RDY_B] = grant_q & tmr_idle;
    ctl_rdata[CS_B]  = bits_q[2];
    ctl_rdata[SK_B]  = bits_q[1];
    ctl_rdata[DO_B]  = bits_q[0];
    ctl_rdata[DI_B]  = din_q;
    ee_owns_port     = grant_q;
    ee_cs            = pins[2];
    ee_clk           = pins[1];
    ee_dout          = pins[0];
  end
endmodule

// File: rtl/sprom_port_arb_chk.sv
module sprom_port_arb_chk #(
  parameter int unsigned PACE_CYC = 100
) (
  input logic       clk,
  input logic       rst,
  input logic       ctl_wr,
  input logic       wr_req,
  input logic [7:0] ctl_rdata,
  input logic       mem_busy,
  input logic       ee_owns_port,
  input logic       ee_cs,
  input logic       ee_clk,
  input logic       ee_dout
);
  localparam int unsigned SW = $clog2(PACE_CYC + 2);
  localparam logic [SW-1:0] SAT = SW'(PACE_CYC + 1);

  logic [SW-1:0] since_wr;
  always_ff @(posedge clk) begin
    if (rst)                         since_wr <= '0;
    else if (ctl_wr && ee_owns_port) since_wr <= '0;
    else if (since_wr != SAT)        since_wr <= since_wr + 1'b1;
  end

  AST_NO_GRANT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!ee_owns_port && mem_busy) |=> !ee_owns_port); // R3
  AST_RDY_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[4] |-> ee_owns_port); // R2
  AST_WRITE_DROPS_RDY: assert property (@(posedge clk) disable iff (rst)
    (ee_owns_port && ctl_wr) |=> !ctl_rdata[4]); // R4
  AST_RDY_ON_TIME: assert property (@(posedge clk) disable iff (rst)
    ($rose(ctl_rdata[4]) && $past(ee_owns_port)) |-> (since_wr == SW'(PACE_CYC))); // R5
  AST_PINS_NEED_GRANT: assert property (@(posedge clk) disable iff (rst)
    !ee_owns_port |-> !(ee_cs || ee_clk || ee_dout)); // R6
  AST_DIN_GATED: assert property (@(posedge clk) disable iff (rst)
    !ee_owns_port |=> !ctl_rdata[0]); // R7
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !wr_req) |=> !ee_owns_port); // R8
  AST_HOLD_OWNED: assert property (@(posedge clk) disable iff (rst)
    (ee_owns_port && !ctl_wr) |=> ee_owns_port); // R9
endmodule

bind sprom_port_arb sprom_port_arb_chk #(.PACE_CYC(PACE_CYC)) u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .wr_req(ctl_wdata[5]),
  .ctl_rdata(ctl_rdata), .mem_busy(mem_busy), .ee_owns_port(ee_owns_port),
  .ee_cs(ee_cs), .ee_clk(ee_clk), .ee_dout(ee_dout)
);

// File: tb/sim_sprom_port_arb.sv
module sim_sprom_port_arb;
  localparam int N = 100; // 125 MHz x 800 ns

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       mem_busy = 1'b0;
  logic       ee_owns_port, ee_cs, ee_clk, ee_dout;
  logic       ee_din = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    string      tag;
    logic [11:0] exp;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  sprom_port_arb u0 (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .mem_busy(mem_busy), .ee_owns_port(ee_owns_port),
    .ee_cs(ee_cs), .ee_clk(ee_clk), .ee_dout(ee_dout), .ee_din(ee_din)
  );

  // Monitor: observed {owns, cs, clk, dout, rdata} compared at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [11:0] act;
      it  = sb.pop_front();
      act = {ee_owns_port, ee_cs, ee_clk, ee_dout, ctl_rdata};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %03h expected %03h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_obs(input string tag, input logic [11:0] e);
    item_t it;
    it.tag = tag;
    it.exp = e;
    sb.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk) #1;
  endtask

  task automatic write_reg(input logic [7:0] d);
    ctl_wr    = 1'b1;
    ctl_wdata = d;
    tick();
    ctl_wr    = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    expect_obs("R1 reset state", 12'h000);

    mem_busy = 1'b1;
    tick();
    write_reg(8'h20);
    expect_obs("R3 pending while busy", 12'h020);
    repeat (300) tick();
    expect_obs("R3 still waiting no timeout", 12'h020);

    mem_busy = 1'b0;
    tick();
    expect_obs("R3 grant on idle, R2 ready at once", 12'h830);

    mem_busy = 1'b1;
    repeat (5) tick();
    expect_obs("R9 busy ignored when owned", 12'h830);

    write_reg(8'h28);
    expect_obs("R4 write drops ready, R6 select pin", 12'hC28);
    repeat (N - 1) tick();
    expect_obs("R4 last low cycle", 12'hC28);
    tick();
    expect_obs("R4 ready back after window", 12'hC38);

    write_reg(8'h2C);
    expect_obs("R6 clock pin", 12'hE2C);
    repeat (50) tick();
    write_reg(8'h2E);
    expect_obs("R5 restart mid window, R6 data pin", 12'hF2E);
    repeat (N - 1) tick();
    expect_obs("R5 still low after restart", 12'hF2E);
    tick();
    expect_obs("R5 ready after restarted window", 12'hF3E);

    ee_din = 1'b1;
    tick();
    expect_obs("R7 data-in high", 12'hF3F);
    ee_din = 1'b0;
    tick();
    expect_obs("R7 data-in low", 12'hF3E);

    ee_din = 1'b1;
    write_reg(8'h2A);
    expect_obs("R6 pins follow write", 12'hD2B);
    write_reg(8'h0A);
    expect_obs("R8 release pins low", 12'h00B);
    tick();
    expect_obs("R8 R7 data-in gated after release", 12'h00A);

    mem_busy = 1'b0;
    ee_din   = 1'b0;
    write_reg(8'h20);
    expect_obs("R2 direct grant, R8 window cancelled", 12'h830);

    mem_busy = 1'b1;
    write_reg(8'h00);
    expect_obs("R8 release while other side busy", 12'h000);

    tick();
    tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule